// File: doc/BRIEF.md
# Banked Wide-Access Scheduler

This block schedules one warp-wide scratchpad request in which each of 32 lanes names a 16-byte, four-word access. The scratchpad behind it has 32 banks, each one 32-bit word wide, so one cycle can move at most 128 bytes. Each lane's access fills four adjacent banks. The scheduler splits the warp into four groups of eight consecutive lanes and serves the groups one after another. Inside a group it resolves bank collisions by spreading them over extra cycles.

Conflicts are only looked for among the eight lanes of one group. Two lanes in different groups can use the same banks without any cost. A warp whose groups each cover all 32 banks therefore finishes in four service cycles, however the groups line up against one another. In every service cycle the block drives a per-bank enable and row index, and it flags the lanes whose access completed in that cycle. It ends each request with a one-cycle done pulse that carries the number of service cycles used. A request that contains any misaligned lane address is dropped whole: it causes no bank activity and ends with an error flag.

Top module: `wa_sched`

## Requirements
- R1: After synchronous reset, ready is 1 and done, err, every bank_en bit and every lane_done bit are 0.
- R2: A request is taken at a rising edge where req_valid and ready are both 1. ready is 0 from the next cycle until the cycle after done. req_valid and req_addr have no effect on any output while ready is 0. While ready is 1, bank_en and lane_done are all zero.
- R3: For a lane address A, the starting bank is s = A[6:2] (a multiple of 4, equal to 4*A[6:4]). Word w of the lane goes to bank s+w at row A[15:7].
- R4: Lanes are served in groups 0-7, 8-15, 16-23 and 24-31, in that order. In any service cycle, bank_en and lane_done come only from lanes of the current group. Lanes in different groups never delay one another.
- R5: In each service cycle, every bank is granted to the lowest-numbered lane of the current group that still has a pending word in that bank. The bank_row slice for bank k (bits k*9 to k*9+8) carries that lane's row.
- R6: lane_done[l] is 1 in exactly the cycle in which all four words of lane l are served. Each lane reports done exactly once per accepted aligned request.
- R7: A group takes as many cycles as the largest number of its lanes that share the same starting bank. The request takes the sum over its groups: 4 when no group has a conflict, 8 when every group has a two-way conflict, and 32 when all eight lanes of every group share one starting bank.
- R8: done is a one-cycle pulse in the cycle after the last service cycle, and cycles equals the number of service cycles while done is 1.
- R9: If any lane address has A[3:0] nonzero, the request causes no bank_en and no lane_done activity. done is then 1 for the next cycle only, together with err = 1 and cycles = 0. err is 0 at all other times.
- R10: ready is 1 in the cycle right after done, so a new request can be taken then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 512 | Lane l byte address in bits l*16 to l*16+15 |
| ready | output | 1 | Block idle and able to take a request |
| bank_en | output | 32 | Bank k accessed in this cycle |
| bank_row | output | 288 | Row index for bank k in bits k*9 to k*9+8 |
| lane_done | output | 32 | Lane finished all four words in this cycle |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request dropped for misalignment (with done) |
| cycles | output | 6 | Service cycles used, valid with done |

## Verification
The assertions assume that reset is applied before the first request. They also assume that req_valid is only sampled as a request while ready is high; anything driven on req_valid or req_addr while ready is low is treated as noise. The bench leans on that second point on purpose. During some busy periods it holds req_valid high and puts a misaligned junk address on the bus, then expects the trace of the request in progress to stay unchanged. Every genuine request it makes is launched from an idle cycle, which keeps the lane-completion tracking in the checker aligned with request boundaries.

// File: rtl/wa_pkg.sv
package wa_pkg;

    localparam int unsigned DEF_LANES        = 32;
    localparam int unsigned DEF_BANKS        = 32;
    localparam int unsigned DEF_WORD_BYTES   = 4;
    localparam int unsigned DEF_ACCESS_WORDS = 4;
    localparam int unsigned DEF_ADDR_W       = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sched_state_t;

    // width of an index able to address n items, never below 1
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wa_align_check.sv
module wa_align_check #(
    parameter int unsigned LANES   = 32,
    parameter int unsigned ALIGN_W = 4
) (
    input  logic [LANES-1:0][ALIGN_W-1:0] low_bits,
    output logic                          any_bad
);

    logic [LANES-1:0] bad;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign bad[l] = |low_bits[l];
    end

    assign any_bad = |bad;

endmodule

// File: rtl/wa_bank_arbiter.sv
module wa_bank_arbiter #(
    parameter int unsigned GL     = 8,
    parameter int unsigned AW     = 4,
    parameter int unsigned BANKS  = 32,
    parameter int unsigned QUAD_W = 3,
    parameter int unsigned ROW_W  = 9,
    parameter int unsigned GLW    = 3
) (
    input  logic [GL-1:0][QUAD_W-1:0] quad,
    input  logic [GL-1:0][ROW_W-1:0]  row,
    input  logic [GL-1:0][AW-1:0]     pend,
    output logic [GL-1:0][AW-1:0]     grant,
    output logic [BANKS-1:0]          en,
    output logic [BANKS-1:0][ROW_W-1:0] brow
);

    // Per bank: scan lanes from highest to lowest so the lowest pending wins.
    always_comb begin
        logic           hit;
        logic [GLW-1:0] sel;
        grant = '0;
        en    = '0;
        brow  = '0;
        for (int k = 0; k < BANKS; k++) begin
            hit = 1'b0;
            sel = '0;
            for (int l = GL - 1; l >= 0; l--) begin
                if (quad[l] == QUAD_W'(k / AW) && pend[l][k % AW]) begin
                    hit = 1'b1;
                    sel = GLW'(l);
                end
            end
            if (hit) begin
                en[k]               = 1'b1;
                brow[k]             = row[sel];
                grant[sel][k % AW]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wa_lane_tracker.sv
module wa_lane_tracker #(
    parameter int unsigned GL = 8,
    parameter int unsigned AW = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  step,
    input  logic [GL-1:0][AW-1:0] grant,
    output logic [GL-1:0][AW-1:0] pend,
    output logic [GL-1:0]         lane_fin,
    output logic                  grp_clear
);

    logic [GL-1:0][AW-1:0] nxt;

    always_comb begin
        for (int l = 0; l < GL; l++) begin
            nxt[l]      = pend[l] & ~grant[l];
            lane_fin[l] = step && (|pend[l]) && (nxt[l] == '0);
        end
        grp_clear = step && (nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)       pend <= '0;
        else if (load) pend <= '1;
        else if (step) pend <= nxt;
    end

endmodule

// File: rtl/wa_sched.sv
module wa_sched
    import wa_pkg::*;
#(
    parameter  int unsigned LANES        = DEF_LANES,
    parameter  int unsigned BANKS        = DEF_BANKS,
    parameter  int unsigned WORD_BYTES   = DEF_WORD_BYTES,
    parameter  int unsigned ACCESS_WORDS = DEF_ACCESS_WORDS,
    parameter  int unsigned ADDR_W       = DEF_ADDR_W,
    localparam int unsigned ROW_W        = ADDR_W - $clog2(BANKS * WORD_BYTES),
    localparam int unsigned CNT_W        = $clog2(LANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [LANES*ADDR_W-1:0]  req_addr,
    output logic                     ready,
    output logic [BANKS-1:0]         bank_en,
    output logic [BANKS*ROW_W-1:0]   bank_row,
    output logic [LANES-1:0]         lane_done,
    output logic                     done,
    output logic                     err,
    output logic [CNT_W-1:0]         cycles
);

    localparam int unsigned ALIGN_W = $clog2(WORD_BYTES * ACCESS_WORDS);
    localparam int unsigned GL      = BANKS / ACCESS_WORDS;
    localparam int unsigned GLW     = idx_w(GL);
    localparam int unsigned QUAD_W  = idx_w(GL);
    localparam int unsigned GROUPS  = LANES / GL;
    localparam int unsigned GRP_W   = idx_w(GROUPS);
    localparam int unsigned LANE_W  = idx_w(LANES);
    localparam int unsigned HI_W    = ADDR_W - ALIGN_W;

    sched_state_t                 state_q;
    logic [GRP_W-1:0]             grp_q;
    logic [CNT_W-1:0]             cnt_q;
    logic                         err_q;
    logic [LANES-1:0][HI_W-1:0]   hi_q;

    logic [LANES-1:0][ALIGN_W-1:0] low_bits;
    logic                          any_bad;
    logic                          accept;
    logic                          run;

    logic [GL-1:0][QUAD_W-1:0]     g_quad;
    logic [GL-1:0][ROW_W-1:0]      g_row;
    logic [GL-1:0][ACCESS_WORDS-1:0] pend;
    logic [GL-1:0][ACCESS_WORDS-1:0] grant;
    logic [GL-1:0]                 lane_fin;
    logic                          grp_clear;
    logic [BANKS-1:0]              arb_en;
    logic [BANKS-1:0][ROW_W-1:0]   arb_row;
    logic                          last_grp;
    logic                          load;

    for (genvar l = 0; l < LANES; l++) begin : g_split
        assign low_bits[l] = req_addr[l*ADDR_W +: ALIGN_W];
    end

    wa_align_check #(
        .LANES   (LANES),
        .ALIGN_W (ALIGN_W)
    ) u_align (
        .low_bits (low_bits),
        .any_bad  (any_bad)
    );

    assign ready    = (state_q == ST_IDLE);
    assign run      = (state_q == ST_RUN);
    assign accept   = ready && req_valid;
    assign last_grp = (grp_q == GRP_W'(GROUPS - 1));
    assign load     = (accept && !any_bad) || (grp_clear && !last_grp);

    // Gather the current group's bank quad and row fields.
    always_comb begin
        logic [LANE_W-1:0] idx;
        for (int l = 0; l < GL; l++) begin
            idx       = LANE_W'(grp_q) * LANE_W'(GL) + LANE_W'(l);
            g_quad[l] = hi_q[idx][QUAD_W-1:0];
            g_row[l]  = hi_q[idx][HI_W-1:QUAD_W];
        end
    end

    wa_bank_arbiter #(
        .GL     (GL),
        .AW     (ACCESS_WORDS),
        .BANKS  (BANKS),
        .QUAD_W (QUAD_W),
        .ROW_W  (ROW_W),
        .GLW    (GLW)
    ) u_arb (
        .quad  (g_quad),
        .row   (g_row),
        .pend  (pend),
        .grant (grant),
        .en    (arb_en),
        .brow  (arb_row)
    );

    wa_lane_tracker #(
        .GL (GL),
        .AW (ACCESS_WORDS)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (run),
        .grant     (grant),
        .pend      (pend),
        .lane_fin  (lane_fin),
        .grp_clear (grp_clear)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
        end else if (accept) begin
            for (int l = 0; l < LANES; l++) begin
                hi_q[l] <= req_addr[l*ADDR_W + ALIGN_W +: HI_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            grp_q   <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        grp_q <= '0;
                        cnt_q <= '0;
                        if (any_bad) begin
                            state_q <= ST_FIN;
                            err_q   <= 1'b1;
                        end else begin
                            state_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (grp_clear) begin
                        if (last_grp) state_q <= ST_FIN;
                        else          grp_q   <= grp_q + 1'b1;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                    err_q   <= 1'b0;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done    = (state_q == ST_FIN);
    assign err     = err_q;
    assign cycles  = cnt_q;
    assign bank_en = run ? arb_en : '0;

    for (genvar k = 0; k < BANKS; k++) begin : g_row_out
        assign bank_row[k*ROW_W +: ROW_W] = (run && arb_en[k]) ? arb_row[k] : '0;
    end

    always_comb begin
        logic [LANE_W-1:0] idx;
        lane_done = '0;
        for (int l = 0; l < GL; l++) begin
            idx = LANE_W'(grp_q) * LANE_W'(GL) + LANE_W'(l);
            if (run) lane_done[idx] = lane_fin[l];
        end
    end

endmodule

// File: rtl/wa_sched_chk.sv
module wa_sched_chk #(
    parameter int unsigned LANES        = 32,
    parameter int unsigned BANKS        = 32,
    parameter int unsigned ACCESS_WORDS = 4,
    parameter int unsigned CNT_W        = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             ready,
    input logic [BANKS-1:0] bank_en,
    input logic [LANES-1:0] lane_done,
    input logic             done,
    input logic             err,
    input logic [CNT_W-1:0] cycles
);

    localparam int unsigned GL     = BANKS / ACCESS_WORDS;
    localparam int unsigned GROUPS = LANES / GL;

    logic [LANES-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)                    seen <= '0;
        else if (req_valid && ready) seen <= '0;
        else                        seen <= seen | lane_done;
    end

    function automatic logic quads_whole(input logic [BANKS-1:0] e);
        logic ok;
        ok = 1'b1;
        for (int q = 0; q < GL; q++) begin
            if (e[q*ACCESS_WORDS +: ACCESS_WORDS] != '0 &&
                e[q*ACCESS_WORDS +: ACCESS_WORDS] != '1) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic one_group(input logic [LANES-1:0] d);
        int n;
        n = 0;
        for (int g = 0; g < GROUPS; g++) begin
            if (d[g*GL +: GL] != '0) n++;
        end
        return n <= 1;
    endfunction

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> !ready);                                  // R2
    AST_QUIET_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        ready |-> (bank_en == '0 && lane_done == '0));                     // R2
    AST_WHOLE_QUADS: assert property (@(posedge clk) disable iff (rst)
        quads_whole(bank_en));                                             // R3
    AST_ONE_GROUP: assert property (@(posedge clk) disable iff (rst)
        one_group(lane_done));                                             // R4
    AST_LANE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (lane_done != '0) |-> ((lane_done & seen) == '0));                 // R6
    AST_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (seen == '1));                                  // R6
    AST_CYCLE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (cycles >= CNT_W'(GROUPS) && cycles <= CNT_W'(LANES))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                   // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && cycles == '0 && bank_en == '0));                  // R9
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> ready);                                                   // R10

endmodule

bind wa_sched wa_sched_chk #(
    .LANES        (LANES),
    .BANKS        (BANKS),
    .ACCESS_WORDS (ACCESS_WORDS),
    .CNT_W        (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ready     (ready),
    .bank_en   (bank_en),
    .lane_done (lane_done),
    .done      (done),
    .err       (err),
    .cycles    (cycles)
);

// File: tb/wa_sched_test.sv
module wa_sched_test;

    localparam int LANES  = 32;
    localparam int BANKS  = 32;
    localparam int ADDR_W = 16;
    localparam int ROW_W  = 9;
    localparam int CNT_W  = 6;
    localparam int RW     = BANKS * ROW_W;

    typedef struct {
        logic [BANKS-1:0] en;
        logic [LANES-1:0] ld;
        logic [RW-1:0]    rows;
        bit               dn;
        bit               er;
        int               cyc;
        string            tag;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    req_valid = 1'b0;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic                    ready;
    logic [BANKS-1:0]        bank_en;
    logic [RW-1:0]           bank_row;
    logic [LANES-1:0]        lane_done;
    logic                    done;
    logic                    err;
    logic [CNT_W-1:0]        cycles;

    exp_t             expq[$];
    logic [ADDR_W-1:0] a [LANES];
    int  total = 0;
    int  bad   = 0;
    bit  monitor_on = 0;
    bit  want_ready = 0;
    bit  finished   = 0;
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    wa_sched uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .ready     (ready),
        .bank_en   (bank_en),
        .bank_row  (bank_row),
        .lane_done (lane_done),
        .done      (done),
        .err       (err),
        .cycles    (cycles)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [RW-1:0] act, input logic [RW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int unsigned next_rand();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    // Expected trace from the requirements (R3, R5, R7, R8, R9).
    task automatic build_expect(input string tag);
        exp_t e;
        bit   mis = 0;
        int   tot = 0;
        for (int l = 0; l < LANES; l++) if (a[l][3:0] != 4'd0) mis = 1;
        if (mis) begin
            e = '{en: '0, ld: '0, rows: '0, dn: 1, er: 1, cyc: 0, tag: tag};
            expq.push_back(e);
            return;
        end
        for (int g = 0; g < LANES / 8; g++) begin
            for (int r = 0; r < 8; r++) begin
                bit any = 0;
                e = '{en: '0, ld: '0, rows: '0, dn: 0, er: 0, cyc: 0, tag: tag};
                for (int i = 0; i < 8; i++) begin
                    int l = g * 8 + i;
                    int rank = 0;
                    for (int m = g * 8; m < l; m++) if (a[m][6:4] == a[l][6:4]) rank++;
                    if (rank == r) begin
                        int q = int'(a[l][6:4]);
                        any = 1;
                        e.ld[l] = 1'b1;
                        for (int w = 0; w < 4; w++) begin
                            e.en[q*4 + w] = 1'b1;
                            e.rows[(q*4 + w)*ROW_W +: ROW_W] = a[l][15:7];
                        end
                    end
                end
                if (!any) break;
                expq.push_back(e);
                tot++;
            end
        end
        e = '{en: '0, ld: '0, rows: '0, dn: 1, er: 0, cyc: tot, tag: tag};
        expq.push_back(e);
    endtask

    task automatic send(input string tag, input bit junk);
        @(negedge clk);
        while (!ready) @(negedge clk);
        for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = a[l];
        build_expect(tag);
        req_valid = 1'b1;
        @(negedge clk);
        if (junk) begin
            // R2: requests offered while busy must not disturb anything
            for (int c = 0; c < 3; c++) begin
                for (int l = 0; l < LANES; l++)
                    req_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(next_rand()) | 16'h0003;
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (monitor_on) begin
            if (!ready) begin
                if (expq.size() == 0) begin
                    check(0, "R2", "busy with nothing expected", RW'(ready), RW'(1));
                end else begin
                    exp_t e;
                    logic [RW-1:0] m;
                    e = expq.pop_front();
                    m = '0;
                    for (int k = 0; k < BANKS; k++)
                        if (e.en[k]) m[k*ROW_W +: ROW_W] = bank_row[k*ROW_W +: ROW_W];
                    check(bank_en == e.en, e.dn ? "R9" : "R3", {e.tag, " bank_en"},
                          RW'(bank_en), RW'(e.en));
                    check(m == e.rows, "R5", {e.tag, " bank_row"}, m, e.rows);
                    check(lane_done == e.ld, "R6", {e.tag, " lane_done"},
                          RW'(lane_done), RW'(e.ld));
                    check(done == e.dn, "R8", {e.tag, " done"}, RW'(done), RW'(e.dn));
                    check(err == e.er, "R9", {e.tag, " err"}, RW'(err), RW'(e.er));
                    if (e.dn) begin
                        check(int'(cycles) == e.cyc, "R7", {e.tag, " cycles"},
                              RW'(cycles), RW'(e.cyc));
                        want_ready = 1;
                    end
                end
            end else begin
                if (want_ready) begin
                    check(1'b1, "R10", "ready after done", RW'(ready), RW'(1));
                    want_ready = 0;
                end
                check(bank_en == '0 && lane_done == '0 && !done && !err, "R2",
                      "idle outputs quiet", RW'({bank_en, lane_done}), RW'(0));
            end
            if (want_ready && expq.size() == 0 && !done) begin
                check(ready == 1'b1, "R10", "ready after done", RW'(ready), RW'(1));
                want_ready = 0;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        check(0, "R8", "watchdog expired", RW'(0), RW'(1));
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ready == 1'b1, "R1", "ready after reset", RW'(ready), RW'(1));
        check(!done && !err, "R1", "done/err after reset", RW'({done, err}), RW'(0));
        check(bank_en == '0 && lane_done == '0, "R1", "enables after reset",
              RW'({bank_en, lane_done}), RW'(0));
        monitor_on = 1;

        // R3 R7: contiguous lanes, no conflict -> 4 cycles
        for (int l = 0; l < LANES; l++) a[l] = ADDR_W'(l * 16);
        send("R7 contiguous", 0);

        // R4: every group hits banks 0-31 at the same rows -> still 4 cycles
        for (int l = 0; l < LANES; l++) a[l] = ADDR_W'((l % 8) * 16);
        send("R4 column", 0);

        // R7: two-way conflict in every group -> 8 cycles
        for (int l = 0; l < LANES; l++) begin
            int i = l % 8;
            int g = l / 8;
            a[l] = ADDR_W'(((i % 4) + 4 * (g % 2)) * 16 + (i / 4 + 2 * g) * 128);
        end
        send("R7 two-way", 1);

        // R5 R7: all lanes of a group share one starting bank -> 32 cycles
        for (int l = 0; l < LANES; l++) a[l] = ADDR_W'(3 * 16 + l * 128);
        send("R5 hot bank", 0);

        // R5 R6: pseudo-random aligned patterns, some with busy-time junk (R2)
        for (int t = 0; t < 6; t++) begin
            for (int l = 0; l < LANES; l++)
                a[l] = ADDR_W'(next_rand()) & 16'hFFF0;
            send("R5 random", t[0]);
        end

        // R9: misaligned lanes drop the request
        for (int l = 0; l < LANES; l++) a[l] = ADDR_W'(l * 16);
        a[13] = a[13] + 16'd8;
        send("R9 misaligned", 0);
        a[13] = ADDR_W'(13 * 16);
        a[0]  = 16'd1;
        send("R9 misaligned lane0", 0);

        // R10: aligned request back to back after the error
        a[0] = 16'd0;
        send("R10 back-to-back", 0);

        @(negedge clk);
        while (!ready || expq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        summary();
    end

endmodule